// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in a small on-chip RAM that a host processor shares with it. Each descriptor has two 32-bit words: a control and status word and a buffer pointer word. The host fills in a descriptor and sets its ready flag. The engine finds the ready descriptor, gives the pointer, the length and the per-frame pad and CRC enables to a transmit MAC core, and waits for that core to report a completion status.

When the frame finishes, the engine writes the status into the same descriptor and clears the ready flag, which hands ownership back to the host. It then raises a one-cycle event and moves on to the next slot. The end of the ring is set by a per-descriptor wrap flag or by the last physical slot. An enable input controls fetching. When enable is removed, the engine lets a frame already under way finish, then returns to slot 0.

The descriptor RAM port uses word addresses. Descriptor `i` occupies word `2*i` (control) and word `2*i+1` (pointer). Read data appears one cycle after a read request.

Top module: `tdr_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mac_req`, `dr_req`, `ev_done` and `ev_err` are all low.
- R2: The control word of slot `i` is read at word address `2*i`. The pointer word is read at `2*i+1` after that slot's ready flag (bit 15) has been seen set.
- R3: If the control word read shows bit 15 clear, no frame is requested and the engine reads the same address again.
- R4: For a ready descriptor, `mac_req` rises with `mac_ptr` equal to word 1, `mac_len` equal to word 0 bits 31:16, `mac_pad` equal to bit 12 and `mac_crc` equal to bit 11. All of these hold steady until `mac_done`.
- R5: In the cycle after `mac_done`, exactly one write to word `2*i` occurs. It carries bit 15 cleared, bits 8:0 equal to `mac_stat` (bit 8 underrun, bits 7:4 retries, bit 3 retry limit, bit 2 late collision, bit 1 defer, bit 0 carrier lost), and all other bits (length, 14 interrupt request, 13 wrap, 12 pad, 11 CRC, 10:9) unchanged.
- R6: After the write-back, the next slot fetched is `i+1`. It is slot 0 if bit 13 was set or if `i` is the last slot (`RING_SLOTS-1`).
- R7: One cycle after the write-back, if bit 14 is set, `ev_done` pulses when the status is zero and `ev_err` pulses when it is non-zero. If bit 14 is clear, neither pulses, and the two never pulse together.
- R8: With `en` low, no new descriptor is read. A frame already requested is still completed and written back, after which the engine's pointer is slot 0 when `en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Fetch enable |
| dr_req | output | 1 | Descriptor RAM access strobe |
| dr_we | output | 1 | Descriptor RAM write (else read) |
| dr_addr | output | $clog2(RING_SLOTS)+1 | Descriptor RAM word address |
| dr_wdata | output | 32 | Write data (control word) |
| dr_rdata | input | 32 | Read data, valid the cycle after a read |
| mac_req | output | 1 | Frame request to MAC, held until done |
| mac_ptr | output | 32 | Frame buffer pointer |
| mac_len | output | 16 | Frame length in bytes |
| mac_pad | output | 1 | Pad enable for this frame |
| mac_crc | output | 1 | CRC append enable for this frame |
| mac_done | input | 1 | One-cycle completion from MAC |
| mac_stat | input | 9 | Completion status, valid with `mac_done` |
| ev_done | output | 1 | Frame-sent event pulse |
| ev_err | output | 1 | Frame-error event pulse |

## Verification
The ring is first left empty so that the engine is seen polling slot 0 without requesting a frame. Slots are then armed with mixed flags, covering clean and failing status with the interrupt request set and a clean frame with it clear. This separates the done event, the error event and silence. A descriptor carrying the wrap flag is followed by a ready slot that must not be served, and a full lap with no wrap flags shows the return from the last physical slot. Finally, enable is removed during a frame, with the next slot already ready, to tell "finish then return to 0" apart from both aborting and continuing.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int STAT_W = 9;

    // Control/status word layout: bit positions are decoded by host software.
    typedef struct packed {
        logic [LEN_W-1:0]  len;     // 31:16
        logic              ready;   // 15
        logic              irq;     // 14
        logic              wrap;    // 13
        logic              pad;     // 12
        logic              crc;     // 11
        logic [1:0]        spare;   // 10:9, preserved
        logic [STAT_W-1:0] stat;    // 8:0
    } ctl_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_RD,
        ST_POLL_CHK,
        ST_PTR_RD,
        ST_PTR_CAP,
        ST_XMIT,
        ST_WBACK
    } tdr_state_e;

    // Hand a descriptor back to the host: drop ownership, insert status.
    function automatic ctl_word_t close_desc(ctl_word_t w, logic [STAT_W-1:0] st);
        ctl_word_t r;
        r       = w;
        r.ready = 1'b0;
        r.stat  = st;
        return r;
    endfunction

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
    parameter int RING_SLOTS = 8,
    localparam int IDX_W = (RING_SLOTS > 1) ? $clog2(RING_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             wrap_flag,
    input  logic             restart,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap_flag || idx == LAST) idx <= '0;
            else                          idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/tdr_seq.sv
module tdr_seq
    import tdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] rdata,
    input  logic              mac_done,
    input  logic [STAT_W-1:0] mac_stat,
    output logic              ram_req,
    output logic              ram_we,
    output logic              word_sel,
    output logic [WORD_W-1:0] wdata,
    output logic              mac_req,
    output logic [WORD_W-1:0] mac_ptr,
    output logic [LEN_W-1:0]  mac_len,
    output logic              mac_pad,
    output logic              mac_crc,
    output logic              advance,
    output logic              wrap_flag,
    output logic              restart,
    output logic              fire,
    output logic              fire_irq,
    output logic              fire_err
);
    tdr_state_e        state;
    ctl_word_t         ctl_q;
    ctl_word_t         rd_ctl;
    logic [WORD_W-1:0] ptr_q;
    logic [STAT_W-1:0] stat_q;

    assign rd_ctl = ctl_word_t'(rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctl_q  <= '0;
            ptr_q  <= '0;
            stat_q <= '0;
        end else begin
            case (state)
                ST_IDLE:     if (en) state <= ST_POLL_RD;
                ST_POLL_RD:  state <= ST_POLL_CHK;
                ST_POLL_CHK: begin
                    if (!en) begin
                        state <= ST_IDLE;
                    end else if (rd_ctl.ready) begin
                        ctl_q <= rd_ctl;
                        state <= ST_PTR_RD;
                    end else begin
                        state <= ST_POLL_RD;
                    end
                end
                ST_PTR_RD:   state <= ST_PTR_CAP;
                ST_PTR_CAP: begin
                    ptr_q <= rdata;
                    state <= ST_XMIT;
                end
                ST_XMIT: begin
                    if (mac_done) begin
                        stat_q <= mac_stat;
                        state  <= ST_WBACK;
                    end
                end
                ST_WBACK:    state <= en ? ST_POLL_RD : ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_req   = (state == ST_POLL_RD) || (state == ST_PTR_RD) || (state == ST_WBACK);
        ram_we    = (state == ST_WBACK);
        word_sel  = (state == ST_PTR_RD);
        wdata     = WORD_W'(close_desc(ctl_q, stat_q));
        mac_req   = (state == ST_XMIT);
        mac_ptr   = ptr_q;
        mac_len   = ctl_q.len;
        mac_pad   = ctl_q.pad;
        mac_crc   = ctl_q.crc;
        advance   = (state == ST_WBACK);
        wrap_flag = ctl_q.wrap;
        restart   = !en && ((state == ST_WBACK) || (state == ST_POLL_CHK));
        fire      = (state == ST_WBACK);
        fire_irq  = ctl_q.irq;
        fire_err  = |stat_q;
    end
endmodule

// File: rtl/tdr_events.sv
module tdr_events (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic fire_irq,
    input  logic fire_err,
    output logic ev_done,
    output logic ev_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_done <= 1'b0;
            ev_err  <= 1'b0;
        end else begin
            ev_done <= fire && fire_irq && !fire_err;
            ev_err  <= fire && fire_irq && fire_err;
        end
    end
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
    import tdr_pkg::*;
#(
    parameter int RING_SLOTS = 8,
    localparam int IDX_W = (RING_SLOTS > 1) ? $clog2(RING_SLOTS) : 1,
    localparam int AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic              dr_req,
    output logic              dr_we,
    output logic [AW-1:0]     dr_addr,
    output logic [WORD_W-1:0] dr_wdata,
    input  logic [WORD_W-1:0] dr_rdata,
    output logic              mac_req,
    output logic [WORD_W-1:0] mac_ptr,
    output logic [LEN_W-1:0]  mac_len,
    output logic              mac_pad,
    output logic              mac_crc,
    input  logic              mac_done,
    input  logic [STAT_W-1:0] mac_stat,
    output logic              ev_done,
    output logic              ev_err
);
    logic             word_sel, advance, wrap_flag, restart;
    logic             fire, fire_irq, fire_err;
    logic [IDX_W-1:0] idx;

    tdr_ring_ptr #(.RING_SLOTS(RING_SLOTS)) u_ptr (
        .clk(clk), .rst(rst), .advance(advance), .wrap_flag(wrap_flag),
        .restart(restart), .idx(idx)
    );

    tdr_seq u_seq (
        .clk(clk), .rst(rst), .en(en), .rdata(dr_rdata),
        .mac_done(mac_done), .mac_stat(mac_stat),
        .ram_req(dr_req), .ram_we(dr_we), .word_sel(word_sel), .wdata(dr_wdata),
        .mac_req(mac_req), .mac_ptr(mac_ptr), .mac_len(mac_len),
        .mac_pad(mac_pad), .mac_crc(mac_crc),
        .advance(advance), .wrap_flag(wrap_flag), .restart(restart),
        .fire(fire), .fire_irq(fire_irq), .fire_err(fire_err)
    );

    tdr_events u_ev (
        .clk(clk), .rst(rst), .fire(fire), .fire_irq(fire_irq),
        .fire_err(fire_err), .ev_done(ev_done), .ev_err(ev_err)
    );

    assign dr_addr = {idx, word_sel};
endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk
    import tdr_pkg::*;
#(
    parameter int RING_SLOTS = 8,
    localparam int IDX_W = (RING_SLOTS > 1) ? $clog2(RING_SLOTS) : 1,
    localparam int AW    = IDX_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              dr_req,
    input logic              dr_we,
    input logic [AW-1:0]     dr_addr,
    input logic [WORD_W-1:0] dr_wdata,
    input logic              mac_req,
    input logic [WORD_W-1:0] mac_ptr,
    input logic [LEN_W-1:0]  mac_len,
    input logic              mac_pad,
    input logic              mac_crc,
    input logic              mac_done,
    input logic [STAT_W-1:0] mac_stat,
    input logic              ev_done,
    input logic              ev_err
);
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        mac_req && !mac_done |=> mac_req);

    a_r4_fields_stable: assert property (@(posedge clk) disable iff (rst)
        mac_req && !mac_done |=> $stable(mac_ptr) && $stable(mac_len)
                                 && $stable(mac_pad) && $stable(mac_crc));

    a_r5_wb_after_done: assert property (@(posedge clk) disable iff (rst)
        mac_req && mac_done |=> dr_req && dr_we);

    a_r5_wb_status: assert property (@(posedge clk) disable iff (rst)
        mac_req && mac_done |=> dr_wdata[STAT_W-1:0] == $past(mac_stat));

    a_r5_wb_clears_ready: assert property (@(posedge clk) disable iff (rst)
        dr_req && dr_we |-> !dr_wdata[15]);

    a_r5_wb_only_after_frame: assert property (@(posedge clk) disable iff (rst)
        dr_req && dr_we |-> $past(mac_req && mac_done));

    a_r2_wb_control_word: assert property (@(posedge clk) disable iff (rst)
        dr_req && dr_we |-> dr_addr[0] == 1'b0);

    a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
        !(ev_done && ev_err));

    a_r7_event_after_wb: assert property (@(posedge clk) disable iff (rst)
        ev_done || ev_err |-> $past(dr_req && dr_we));
endmodule

bind tdr_engine tdr_engine_chk #(.RING_SLOTS(RING_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .dr_req(dr_req), .dr_we(dr_we), .dr_addr(dr_addr),
    .dr_wdata(dr_wdata), .mac_req(mac_req), .mac_ptr(mac_ptr),
    .mac_len(mac_len), .mac_pad(mac_pad), .mac_crc(mac_crc),
    .mac_done(mac_done), .mac_stat(mac_stat), .ev_done(ev_done), .ev_err(ev_err)
);

// File: tb/sim_tdr_engine.sv
`timescale 1ns/1ps
module sim_tdr_engine;
    localparam int SLOTS = 8;
    localparam int AW    = $clog2(SLOTS) + 1;

    typedef struct {
        int          idx;
        logic [31:0] ptr;
        logic [15:0] len;
        logic        pad;
        logic        crc;
        logic        irq;
        logic [8:0]  stat;
        logic [31:0] wb;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          dr_req, dr_we;
    logic [AW-1:0] dr_addr;
    logic [31:0]   dr_wdata;
    logic [31:0]   dr_rdata = '0;
    logic          mac_req;
    logic [31:0]   mac_ptr;
    logic [15:0]   mac_len;
    logic          mac_pad, mac_crc;
    logic          mac_done = 1'b0;
    logic [8:0]    mac_stat = '0;
    logic          ev_done, ev_err;

    logic [31:0]   mem [2*SLOTS];
    exp_t          exp_q[$];
    int            checks = 0, errors = 0, frames = 0, rd_count = 0;
    logic [AW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    tdr_engine #(.RING_SLOTS(SLOTS)) u0 (
        .clk(clk), .rst(rst), .en(en), .dr_req(dr_req), .dr_we(dr_we),
        .dr_addr(dr_addr), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
        .mac_req(mac_req), .mac_ptr(mac_ptr), .mac_len(mac_len),
        .mac_pad(mac_pad), .mac_crc(mac_crc), .mac_done(mac_done),
        .mac_stat(mac_stat), .ev_done(ev_done), .ev_err(ev_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Descriptor RAM model, one-cycle read latency.
    initial begin
        for (int i = 0; i < 2*SLOTS; i++) mem[i] = '0;
        forever begin
            @(posedge clk);
            if (dr_req) begin
                if (dr_we) mem[dr_addr] <= dr_wdata;
                else begin
                    dr_rdata <= mem[dr_addr];
                    last_rd  <= dr_addr;
                    rd_count <= rd_count + 1;
                end
            end
        end
    end

    // Driver: arms a descriptor; pushes the expected frame when asked.
    task automatic arm(input int idx, input logic [15:0] len, input logic [31:0] ptr,
                       input logic irq, input logic wrap, input logic pad, input logic crc,
                       input logic [1:0] spare, input logic [8:0] stat, input bit expect_it);
        logic [31:0] w0;
        exp_t e;
        w0 = {len, 1'b1, irq, wrap, pad, crc, spare, 9'h155};
        mem[2*idx+1] = ptr;
        mem[2*idx]   = w0;
        if (expect_it) begin
            e.idx = idx; e.ptr = ptr; e.len = len; e.pad = pad; e.crc = crc;
            e.irq = irq; e.stat = stat;
            e.wb  = {len, 1'b0, irq, wrap, pad, crc, spare, stat};
            exp_q.push_back(e);
        end
    endtask

    // Monitor / MAC responder: pops expected frames and compares.
    initial begin
        exp_t e;
        forever begin
            do @(negedge clk); while (!mac_req);
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected frame ptr", mac_ptr, 0);
                e = '{idx: 0, ptr: 0, len: 0, pad: 0, crc: 0, irq: 0, stat: 0, wb: 0};
            end else begin
                e = exp_q.pop_front();
                chk(mac_ptr == e.ptr, "R4", "frame pointer (R6 order)", mac_ptr, e.ptr);
                chk(mac_len == e.len, "R4", "frame length", 32'(mac_len), 32'(e.len));
                chk({mac_pad, mac_crc} == {e.pad, e.crc}, "R4", "pad/crc",
                    32'({mac_pad, mac_crc}), 32'({e.pad, e.crc}));
                chk(last_rd == AW'(2*e.idx+1), "R2", "pointer word address",
                    32'(last_rd), 32'(2*e.idx+1));
            end
            repeat (3) begin
                @(negedge clk);
                chk(mac_req && mac_ptr == e.ptr, "R4", "request held", 32'(mac_req), 1);
            end
            mac_stat = e.stat;
            mac_done = 1'b1;
            @(negedge clk);
            mac_done = 1'b0;
            chk(dr_req && dr_we, "R5", "write-back strobe", 32'({dr_req, dr_we}), 3);
            chk(dr_addr == AW'(2*e.idx), "R5", "write-back address",
                32'(dr_addr), 32'(2*e.idx));
            chk(dr_wdata == e.wb, "R5", "write-back word", dr_wdata, e.wb);
            @(negedge clk);
            chk(ev_done == (e.irq && e.stat == 0), "R7", "done event",
                32'(ev_done), 32'(e.irq && e.stat == 0));
            chk(ev_err == (e.irq && e.stat != 0), "R7", "error event",
                32'(ev_err), 32'(e.irq && e.stat != 0));
            frames++;
        end
    end

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, bad, reads;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!mac_req && !dr_req && !ev_done && !ev_err, "R1", "outputs in reset",
            32'({mac_req, dr_req, ev_done, ev_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mac_req && !dr_req && !ev_done && !ev_err, "R1", "outputs after reset",
            32'({mac_req, dr_req, ev_done, ev_err}), 0);
        // R8: disabled, no fetch
        base = rd_count;
        repeat (10) @(negedge clk);
        chk(rd_count == base, "R8", "reads while disabled", rd_count - base, 0);

        // R3: empty ring polls slot 0 only
        en = 1'b1;
        bad = 0; reads = 0;
        repeat (30) begin
            @(negedge clk);
            if (mac_req) bad++;
            if (dr_req && !dr_we) begin
                reads++;
                if (dr_addr != 0) bad++;
            end
        end
        chk(bad == 0, "R3", "stray request or address while polling", bad, 0);
        chk(reads >= 10, "R3", "poll reads of slot 0", reads, 10);

        // R4 R5 R7: clean frame with interrupt request
        arm(0, 16'd60, 32'h0000_1000, 1, 0, 1, 1, 2'b10, 9'h000, 1);
        wait_frames(1);

        // R6 R7: error status, silent frame, wrap flag, slot after wrap not served
        arm(1, 16'd1514, 32'h0000_2000, 1, 0, 0, 1, 2'b01, 9'h0A5, 1);
        arm(2, 16'd64,   32'h0000_3000, 0, 0, 1, 0, 2'b00, 9'h000, 1);
        arm(3, 16'd100,  32'h0000_4000, 1, 1, 0, 0, 2'b11, 9'h100, 1);
        arm(4, 16'd200,  32'h0000_5000, 1, 0, 0, 0, 2'b00, 9'h000, 0);
        wait_frames(4);
        repeat (20) @(negedge clk);
        chk(last_rd == 0, "R6", "poll address after wrap flag", 32'(last_rd), 0);
        chk(mem[8][15] == 1'b1, "R6", "slot past wrap left ready", 32'(mem[8][15]), 1);
        chk(!mem[6][15], "R5", "wrap slot ready cleared", 32'(mem[6][15]), 0);
        mem[8] = '0;

        // R6: full lap, no wrap flags, returns from last slot
        for (int i = 0; i < SLOTS; i++)
            arm(i, 16'(64 + i), 32'h0001_0000 + 32'(i * 16'h100), 1, 0, i[0], ~i[0],
                2'(i), 9'h000, 1);
        wait_frames(4 + SLOTS);
        repeat (10) @(negedge clk);
        chk(last_rd == 0, "R6", "poll address after last slot", 32'(last_rd), 0);
        chk(exp_q.size() == 0, "R6", "all lap frames served", exp_q.size(), 0);

        // R8: disable during a frame with the next slot ready
        arm(0, 16'd80, 32'h0002_0000, 1, 0, 1, 1, 2'b00, 9'h002, 1);
        arm(1, 16'd90, 32'h0002_1000, 1, 0, 1, 1, 2'b00, 9'h000, 0);
        do @(negedge clk); while (!mac_req);
        en = 1'b0;
        wait_frames(5 + SLOTS);
        base = rd_count;
        repeat (20) @(negedge clk);
        chk(rd_count == base, "R8", "reads after disable", rd_count - base, 0);
        chk(mem[2][15] == 1'b1, "R8", "next slot untouched", 32'(mem[2][15]), 1);
        en = 1'b1;
        base = rd_count;
        while (rd_count == base) @(negedge clk);
        chk(last_rd == 0, "R8", "first read after re-enable", 32'(last_rd), 0);
        repeat (10) @(negedge clk);
        chk(!mac_req && frames == 5 + SLOTS, "R8", "no frame from slot 1",
            32'(frames), 32'(5 + SLOTS));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule